// File: doc/BRIEF.md
# External Pin Interrupt Controller

The block watches a small set of external pins, two by default, and turns activity on them into interrupt requests for a small processor. Each pin passes through a two-flop synchroniser. A 2-bit sense setting per channel then selects what counts as an event: a low level, any change, a falling edge or a rising edge. Pin direction has no bearing on detection, so a pin that the chip drives itself still raises requests.

Software sees two byte-wide registers on a plain register bus. The enable register holds one bit per channel. The pending register holds one bit per channel, and writing a one to a bit clears it. A channel's pending bit also clears when the processor acknowledges that channel's vector. The block drives a request per channel, gated by the channel's enable bit and by a global interrupt-enable input. It also drives a combined request and the number of the pending channel with the lowest index.

In level mode a channel keeps no pending state. Its pending bit reads zero, and its request follows the synchronised pin directly.

Top module: `extint_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and every request output, `irq_any` and `irq_vec` are zero.
- R2: The register at address 0 is the enable register and the register at address 1 is the pending register. In both, bit i belongs to channel i. Bits 7 to 2 always read zero.
- R3: A write to address 0 loads bits 1:0 of `bus_wdata` into the enable register. The new value is visible from the clock edge that takes the write.
- R4: The sense code of channel i is `sense_cfg[2i+1:2i]`. The codes are 00 for low level, 01 for any change, 10 for a falling edge and 11 for a rising edge. In an edge mode, a matching change on the pin sets the pending bit on the third rising clock edge after the change, because of the two-flop synchroniser.
- R5: A write to address 1 clears every pending bit whose `bus_wdata` bit is one. Bits written as zero keep their value.
- R6: A one on `vec_ack[i]` at a clock edge clears the pending bit of channel i.
- R7: If an event is detected in the same cycle as a clear (by write or by acknowledge), the pending bit ends up set.
- R8: In level mode a channel's pending bit reads zero. Its request is high while the synchronised pin is low, its enable bit is set and `irq_gie` is high.
- R9: In an edge mode a channel's request equals pending AND enable AND `irq_gie`. The pending bit sets whether or not the channel is enabled.
- R10: `irq_any` is the OR of all channel requests. `irq_vec` gives the lowest-indexed channel whose request is active, which means channel 0 wins over channel 1. `irq_vec` is 0 when no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | External interrupt pins, asynchronous |
| sense_cfg | input | 4 | Sense code, 2 bits per channel |
| irq_gie | input | 1 | Global interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = enable, 1 = pending |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| vec_ack | input | 2 | Per-channel vector acknowledge pulse |
| irq_req | output | 2 | Per-channel interrupt request |
| irq_any | output | 1 | OR of all requests |
| irq_vec | output | 1 | Index of the winning channel |

## Verification
The assertions take it for granted that `bus_addr` and `bus_wr` are driven to known values in every cycle. They also take it for granted that `sense_cfg` is a plain input that does not glitch between clock edges. The random stimulus drives every input once per cycle, on the falling clock edge. It changes the sense codes only every few dozen cycles and toggles the pins at a modest rate, so that every edge mode gets to catch isolated events. A reference model in the bench, built from the requirements, predicts the registers and requests in every cycle. Directed sequences place an event exactly on a clearing write, check writes of zero, and drive the reserved bits.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= (g == 0) ? d_i : chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] sense,
  input  logic       en_bit,
  input  logic       gie,
  input  logic       wclr,
  input  logic       ack,
  output logic       pend_q,
  output logic       pend_rd,
  output logic       hit,
  output logic       lvl,
  output logic       req
);
  sense_e mode;
  logic   prev_q;

  assign mode = sense_e'(sense);
  assign lvl  = (mode == SNS_LOW);

  always_comb begin
    unique case (mode)
      SNS_ANY:  hit = pin_s ^ prev_q;
      SNS_FALL: hit = prev_q & ~pin_s;
      SNS_RISE: hit = pin_s & ~prev_q;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (lvl)              pend_q <= 1'b0;
      else if (hit)         pend_q <= 1'b1;
      else if (wclr || ack) pend_q <= 1'b0;
    end
  end

  assign pend_rd = pend_q & ~lvl;
  assign req     = gie & en_bit & (lvl ? ~pin_s : pend_q);
endmodule

// File: rtl/extint_prio.sv
module extint_prio #(
  parameter int NCH = 2,
  localparam int VW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [VW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = VW'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int NCH         = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int VW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pin_i,
  input  logic [2*NCH-1:0] sense_cfg,
  input  logic             irq_gie,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCH-1:0]   vec_ack,
  output logic [NCH-1:0]   irq_req,
  output logic             irq_any,
  output logic [VW-1:0]    irq_vec
);
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_rd;
  logic [NCH-1:0] hit_v;
  logic [NCH-1:0] lvl_v;
  logic           wr_en, wr_pend;
  logic           unused_wdata;

  assign wr_en        = bus_wr & ~bus_addr;
  assign wr_pend      = bus_wr &  bus_addr;
  assign unused_wdata = ^bus_wdata[DW-1:NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata[NCH-1:0];
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i[c]), .q_o(pin_s[c])
      );
      extint_chan u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_s  (pin_s[c]),
        .sense  (sense_cfg[2*c +: 2]),
        .en_bit (en_q[c]),
        .gie    (irq_gie),
        .wclr   (wr_pend & bus_wdata[c]),
        .ack    (vec_ack[c]),
        .pend_q (pend_q[c]),
        .pend_rd(pend_rd[c]),
        .hit    (hit_v[c]),
        .lvl    (lvl_v[c]),
        .req    (irq_req[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    bus_rdata[NCH-1:0] = bus_addr ? pend_rd : en_q;
  end

  extint_prio #(.NCH(NCH)) u_prio (
    .req_i(irq_req), .any_o(irq_any), .idx_o(irq_vec)
  );
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  localparam int VW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_gie,
  input logic           bus_addr,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] vec_ack,
  input logic [NCH-1:0] irq_req,
  input logic [VW-1:0]  irq_vec,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] hit_v,
  input logic [NCH-1:0] lvl_v
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NCH] == '0); // R2
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> irq_gie); // R9
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_q) == '0); // R9
  AST_VEC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> (irq_vec == '0)); // R10

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_a
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack[i] && !hit_v[i]) |=> !pend_q[i]); // R6
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_v[i] |=> pend_q[i]); // R7
      AST_LEVEL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_v[i] && bus_addr) |-> !bus_rdata[i]); // R8
    end
  endgenerate
endmodule

bind extint_ctrl extint_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_gie(irq_gie), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .vec_ack(vec_ack), .irq_req(irq_req),
  .irq_vec(irq_vec), .en_q(en_q), .pend_q(pend_q), .hit_v(hit_v),
  .lvl_v(lvl_v)
);

// File: tb/sim_extint_ctrl.sv
module sim_extint_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_i = '0;
  logic [3:0] sense_cfg = 4'hF;
  logic       irq_gie = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] vec_ack = '0;
  logic [1:0] irq_req;
  logic       irq_any;
  logic [0:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  string ftag = "R4";

  always #5 clk = ~clk;

  extint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sense_cfg(sense_cfg),
    .irq_gie(irq_gie), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vec_ack(vec_ack),
    .irq_req(irq_req), .irq_any(irq_any), .irq_vec(irq_vec)
  );

  // reference model from the requirements
  logic [1:0] m_s1, m_s2, m_p, m_pend, m_en;

  function automatic logic lvl_of(input int ch);
    return sense_cfg[2*ch +: 2] == 2'b00;
  endfunction

  function automatic logic event_of(input int ch);
    case (sense_cfg[2*ch +: 2])
      2'b01:   return m_s2[ch] ^ m_p[ch];
      2'b10:   return m_p[ch] & ~m_s2[ch];
      2'b11:   return m_s2[ch] & ~m_p[ch];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] exp_req();
    logic [1:0] r;
    for (int ch = 0; ch < 2; ch++)
      r[ch] = irq_gie & m_en[ch] & (lvl_of(ch) ? ~m_s2[ch] : m_pend[ch]);
    return r;
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [1:0] f;
    for (int ch = 0; ch < 2; ch++) f[ch] = m_pend[ch] & ~lvl_of(ch);
    return {6'b0, bus_addr ? f : m_en};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_pend <= '0; m_en <= '0;
    end else begin
      m_s1 <= pin_i; m_s2 <= m_s1; m_p <= m_s2;
      if (bus_wr && !bus_addr) m_en <= bus_wdata[1:0];
      for (int ch = 0; ch < 2; ch++) begin
        if (lvl_of(ch)) m_pend[ch] <= 1'b0;
        else if (event_of(ch)) m_pend[ch] <= 1'b1;
        else if ((bus_wr && bus_addr && bus_wdata[ch]) || vec_ack[ch])
          m_pend[ch] <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [1:0] r;
    @(negedge clk);
    r = exp_req();
    chk(bus_addr ? ftag : "R3", bus_rdata, exp_rdata());
    chk((lvl_of(0) || lvl_of(1)) ? "R8" : "R9", {6'b0, irq_req}, {6'b0, r});
    chk("R10", {7'b0, irq_any}, {7'b0, |r});
    chk("R10", {7'b0, irq_vec}, {7'b0, (!r[0] && r[1])});
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset values
    bus_addr = 1'b0; @(negedge clk); chk("R1", bus_rdata, 8'h00);
    bus_addr = 1'b1; @(negedge clk); chk("R1", bus_rdata, 8'h00);
    chk("R1", {5'b0, irq_req, irq_any, irq_vec}, 8'h00);
    rst_n = 1'b1;
    cyc();
    // R2 and R3: reserved bits ignored, enable written
    wr(1'b0, 8'hFF);
    bus_addr = 1'b0; @(negedge clk); chk("R2", bus_rdata, 8'h03);
    irq_gie = 1'b1; sense_cfg = 4'hF; bus_addr = 1'b1;
    // R4: rising edge on pin 0 sets pending on the third edge
    pin_i = 2'b01;
    cyc(); cyc(); chk("R4", bus_rdata, 8'h00);
    cyc(); chk("R4", bus_rdata, 8'h01);
    // R5: write of zero keeps, write of one clears
    ftag = "R5";
    wr(1'b1, 8'h00); cyc(); chk("R5", bus_rdata, 8'h01);
    wr(1'b1, 8'h01); chk("R5", bus_rdata, 8'h00);
    // R6: acknowledge clears channel 1
    ftag = "R6";
    pin_i = 2'b11; repeat (3) cyc(); chk("R6", bus_rdata, 8'h02);
    vec_ack = 2'b10; cyc(); vec_ack = 2'b00; chk("R6", bus_rdata, 8'h00);
    // R7: event on the same edge as a clear
    ftag = "R7";
    sense_cfg = 4'b1010; pin_i = 2'b00;
    cyc(); cyc();
    wr(1'b1, 8'h03); chk("R7", bus_rdata, 8'h03);
    vec_ack = 2'b11; cyc(); vec_ack = 2'b00; chk("R7", bus_rdata, 8'h00);
    // R8: level mode on channel 1
    ftag = "R8";
    sense_cfg = 4'b0011; cyc(); cyc();
    chk("R8", {6'b0, irq_req}, 8'h02);
    ftag = "R4";
    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 50 == 0) sense_cfg = 4'($urandom);
      for (int ch = 0; ch < 2; ch++)
        if ($urandom % 4 == 0) pin_i[ch] = ~pin_i[ch];
      irq_gie  = ($urandom % 8) != 0;
      bus_wr   = ($urandom % 6) == 0;
      bus_addr = 1'($urandom);
      bus_wdata = 8'($urandom);
      vec_ack  = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      cyc();
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule